// File: doc/BRIEF.md
# Single-Channel Bus-Master DMA Channel

This block is one DMA channel that moves bytes between a byte-wide peripheral stream and system memory without processor help. Software sets up a starting memory address and a byte count through a 32-bit register port, then issues a command. The channel then raises one-byte read or write requests on a request/grant memory bus. It advances its current address and lowers its remaining count for every byte that memory accepts, and it reports completion, bus errors, aborts and buffer flushes in a sticky status word. One interrupt output, gated by an enable bit in the command word, signals completion, error and abort.

In the inbound direction (peripheral to memory), bytes gather in a small staging buffer and go to memory in batches. A partly filled buffer can be pushed out on request with the flush command. In the outbound direction (memory to peripheral), each byte read from memory is held in a one-byte register until the peripheral takes it. A single transfer is limited to one 4 KiB segment. Register reads are combinational on the register index and have no strobe. Writes take effect on the clock edge where `reg_wr` is high.

Top module: `busdma_chan`

## Requirements
- R1: After reset the command word reads 0 (idle), the status word reads 0, `mem_req` is low and `irq` is low.
- R2: The registers sit at word indices 0 command, 1 status, 2 start address, 3 start count, 4 current address and 5 remaining count. A start command copies the start address and count into the current address and remaining count. Each byte that memory accepts adds one to the address and takes one from the count. Status bit 0 (done) sets once the count is zero and the staging buffer is empty.
- R3: With the direction bit set, peripheral bytes are written to consecutive memory addresses in arrival order. Memory writes begin only when the buffer is full or holds every byte still owed.
- R4: With the direction bit clear, memory bytes are read from consecutive addresses and presented on `out_data` in address order.
- R5: A start with a count of zero never raises `mem_req`, and it still sets done.
- R6: A start count written above 4096 reads back as 4096.
- R7: Command word fields are: bits 1:0 operation (0 idle, 1 start, 2 flush, 3 abort), bit 4 direction (1 = peripheral to memory) and bit 5 interrupt enable. The word reads back as written, and any operation other than idle means busy.
- R8: Abort stops all requests at once, discards buffered bytes and sets status bit 2. A later idle command returns the command word to idle.
- R9: The flush command in the inbound direction writes every buffered byte to memory, even a partial batch, and then sets status bit 3.
- R10: An error response with a grant sets status bit 1, leaves the address and count as they were, and blocks all requests until software writes a new command.
- R11: Status bits are sticky, and writing an idle or start command clears all four of them.
- R12: `irq` is high exactly when the enable bit is set and any of done, error or aborted is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Inbound peripheral byte present |
| in_data | input | 8 | Inbound peripheral byte |
| in_ready | output | 1 | Channel takes the inbound byte this cycle |
| out_valid | output | 1 | Outbound byte present |
| out_data | output | 8 | Outbound byte |
| out_ready | input | 1 | Peripheral takes the outbound byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with the grant |
| mem_err | input | 1 | Error response, valid with the grant |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the channel with a four-byte staging buffer, a 32-bit address and the full 4096-byte segment cap. With so small a buffer, every count from 0 to 20 covers empty transfers, transfers that fit in one partial batch, exact multiples of the batch size and multi-batch transfers with a short tail, in both directions. Grants arrive on a pseudo-random pattern, so requests sometimes wait several cycles. A held-back partial batch is exercised through the flush and abort paths, and a single injected error response exercises the request blocking.

// File: rtl/busdma_pkg.sv
`timescale 1ns/1ps
package busdma_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_START = 2'd1,
        OP_FLUSH = 2'd2,
        OP_ABORT = 2'd3
    } dma_op_e;

    localparam logic [2:0] RA_CMD   = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_SADDR = 3'd2;
    localparam logic [2:0] RA_SCNT  = 3'd3;
    localparam logic [2:0] RA_CADDR = 3'd4;
    localparam logic [2:0] RA_REM   = 3'd5;

    localparam int CB_DIR = 4;
    localparam int CB_IEN = 5;

endpackage

// File: rtl/busdma_inbuf.sv
`timescale 1ns/1ps
module busdma_inbuf #(
    parameter int DEPTH = 4,
    localparam int BW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    wdata,
    input  logic          pop,
    output logic [7:0]    rdata,
    output logic [BW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] data;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [BW-1:0]         cnt;
    } buf_t;

    buf_t buf_d, buf_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.rd  = '0;
            buf_d.wr  = '0;
            buf_d.cnt = '0;
        end else begin
            if (push) begin
                buf_d.data[buf_q.wr] = wdata;
                buf_d.wr = step(buf_q.wr);
            end
            if (pop) begin
                buf_d.rd = step(buf_q.rd);
            end
            buf_d.cnt = buf_q.cnt + BW'(push) - BW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rdata = buf_q.data[buf_q.rd];
    assign count = buf_q.cnt;
    assign full  = (buf_q.cnt == BW'(DEPTH));
    assign empty = (buf_q.cnt == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> !empty);

endmodule

// File: rtl/busdma_ctrl.sv
`timescale 1ns/1ps
module busdma_ctrl
    import busdma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_SEG = 4096,
    parameter int DEPTH   = 4,
    localparam int CW = $clog2(MAX_SEG + 1),
    localparam int BW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          out_valid,
    output logic [7:0]    out_data,
    input  logic          out_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_err,
    input  logic [BW-1:0] fifo_count,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    output logic          fifo_push,
    output logic          fifo_pop,
    output logic          fifo_clr,
    output dma_op_e       op,
    output logic          dir,
    output logic          ien,
    output logic [AW-1:0] saddr,
    output logic [CW-1:0] scnt,
    output logic [AW-1:0] caddr,
    output logic [CW-1:0] rem,
    output logic [3:0]    status
);

    typedef struct packed {
        dma_op_e       op;
        logic          dir;
        logic          ien;
        logic [AW-1:0] saddr;
        logic [CW-1:0] scnt;
        logic [AW-1:0] caddr;
        logic [CW-1:0] rem;
        logic          done;
        logic          err;
        logic          abt;
        logic          fcmp;
        logic          batch;
        logic          oval;
        logic [7:0]    odat;
    } st_t;

    st_t st_d, st_q;

    logic          cmd_wr;
    dma_op_e       new_op;
    logic [CW-1:0] buf_cnt;
    logic          accept_in, wr_req, rd_req, xfer_ok, xfer_bad;

    always_comb begin
        cmd_wr    = reg_wr && (reg_addr == RA_CMD);
        new_op    = dma_op_e'(reg_wdata[1:0]);
        buf_cnt   = CW'(fifo_count);
        accept_in = (st_q.op == OP_START) && st_q.dir && !st_q.err
                    && !fifo_full && (buf_cnt < st_q.rem);
        wr_req    = ((st_q.op == OP_START) || (st_q.op == OP_FLUSH)) && st_q.dir
                    && !st_q.err && !fifo_empty
                    && (st_q.batch || fifo_full || (buf_cnt == st_q.rem)
                        || (st_q.op == OP_FLUSH));
        rd_req    = (st_q.op == OP_START) && !st_q.dir && !st_q.err
                    && (st_q.rem != '0) && !st_q.oval;
        mem_req   = wr_req || rd_req;
        xfer_ok   = mem_req && mem_gnt && !mem_err && !cmd_wr;
        xfer_bad  = mem_req && mem_gnt &&  mem_err && !cmd_wr;
        fifo_push = in_valid && accept_in && !cmd_wr;
        fifo_pop  = xfer_ok && st_q.dir;
        fifo_clr  = cmd_wr && (new_op != OP_FLUSH);

        st_d = st_q;
        if (xfer_ok) begin
            st_d.caddr = st_q.caddr + AW'(1);
            st_d.rem   = st_q.rem - CW'(1);
            if (!st_q.dir) begin
                st_d.oval = 1'b1;
                st_d.odat = mem_rdata;
            end
        end
        if (xfer_bad) st_d.err = 1'b1;
        if (st_q.oval && out_ready) st_d.oval = 1'b0;
        if (fifo_full) st_d.batch = 1'b1;
        if (fifo_pop && (fifo_count == BW'(1)) && !fifo_push) st_d.batch = 1'b0;
        if ((st_q.op == OP_START) && (st_q.rem == '0) && fifo_empty) st_d.done = 1'b1;
        if ((st_q.op == OP_FLUSH) && st_q.dir && fifo_empty && !st_q.err) st_d.fcmp = 1'b1;

        if (reg_wr) begin
            case (reg_addr)
                RA_SADDR: st_d.saddr = reg_wdata[AW-1:0];
                RA_SCNT:  st_d.scnt  = (reg_wdata > 32'(MAX_SEG)) ? CW'(MAX_SEG)
                                                                    : reg_wdata[CW-1:0];
                RA_CMD: begin
                    st_d.op  = new_op;
                    st_d.dir = reg_wdata[CB_DIR];
                    st_d.ien = reg_wdata[CB_IEN];
                    if (new_op != OP_FLUSH) begin
                        st_d.batch = 1'b0;
                        st_d.oval  = 1'b0;
                    end
                    if ((new_op == OP_IDLE) || (new_op == OP_START)) begin
                        st_d.done = 1'b0;
                        st_d.err  = 1'b0;
                        st_d.abt  = 1'b0;
                        st_d.fcmp = 1'b0;
                    end
                    if (new_op == OP_START) begin
                        st_d.caddr = st_q.saddr;
                        st_d.rem   = st_q.scnt;
                    end
                    if (new_op == OP_ABORT) st_d.abt = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = accept_in;
    assign out_valid = st_q.oval;
    assign out_data  = st_q.odat;
    assign mem_we    = st_q.dir;
    assign mem_addr  = st_q.caddr;
    assign op        = st_q.op;
    assign dir       = st_q.dir;
    assign ien       = st_q.ien;
    assign saddr     = st_q.saddr;
    assign scnt      = st_q.scnt;
    assign caddr     = st_q.caddr;
    assign rem       = st_q.rem;
    assign status    = {st_q.fcmp, st_q.abt, st_q.err, st_q.done};

    assert_quiet_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.op == OP_IDLE) || (st_q.op == OP_ABORT)) |-> !mem_req);
    assert_err_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !mem_req);
    assert_seg_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rem <= CW'(MAX_SEG)) && (st_q.scnt <= CW'(MAX_SEG)));
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !mem_err && !cmd_wr) |=> (st_q.rem == $past(st_q.rem) - CW'(1)));
    assert_done_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.rem) == '0));
    assert_zero_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rem == '0) |-> !mem_req);

endmodule

// File: rtl/busdma_chan.sv
`timescale 1ns/1ps
module busdma_chan
    import busdma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_SEG = 4096,
    parameter int DEPTH   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [7:0]    out_data,
    input  logic          out_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_gnt,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_err,
    output logic          irq
);

    localparam int CW = $clog2(MAX_SEG + 1);
    localparam int BW = $clog2(DEPTH + 1);

    logic [BW-1:0] fifo_count;
    logic          fifo_full, fifo_empty, fifo_push, fifo_pop, fifo_clr;
    dma_op_e       op;
    logic          dir, ien;
    logic [AW-1:0] saddr, caddr;
    logic [CW-1:0] scnt, rem;
    logic [3:0]    status;

    busdma_inbuf #(.DEPTH(DEPTH)) u_inbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (fifo_push),
        .wdata (in_data),
        .pop   (fifo_pop),
        .rdata (mem_wdata),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    busdma_ctrl #(.AW(AW), .MAX_SEG(MAX_SEG), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .fifo_count (fifo_count),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_push  (fifo_push),
        .fifo_pop   (fifo_pop),
        .fifo_clr   (fifo_clr),
        .op         (op),
        .dir        (dir),
        .ien        (ien),
        .saddr      (saddr),
        .scnt       (scnt),
        .caddr      (caddr),
        .rem        (rem),
        .status     (status)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CMD: begin
                reg_rdata[1:0]    = op;
                reg_rdata[CB_DIR] = dir;
                reg_rdata[CB_IEN] = ien;
            end
            RA_STAT:  reg_rdata[3:0]    = status;
            RA_SADDR: reg_rdata[AW-1:0] = saddr;
            RA_SCNT:  reg_rdata[CW-1:0] = scnt;
            RA_CADDR: reg_rdata[AW-1:0] = caddr;
            RA_REM:   reg_rdata[CW-1:0] = rem;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = ien && (status[0] || status[1] || status[2]);

    assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[2:0] != 3'b000));

endmodule

// File: tb/busdma_chan_bench.sv
`timescale 1ns/1ps
module busdma_chan_bench;
    import busdma_pkg::*;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_ready = 1'b1;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_gnt = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic          mem_err = 1'b0;
    logic          irq;

    always #2.5 clk = ~clk;

    busdma_chan #(.AW(AW), .MAX_SEG(4096), .DEPTH(4)) u_busdma_chan (.*);

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] rdv;

    // owned by the negedge model
    logic [7:0]  mem [256];
    logic [7:0]  out_log [512];
    logic [15:0] lfsr = 16'hACE1;
    int fed_cnt = 0, out_cnt = 0, req_cnt = 0;
    logic acc_pend = 1'b0;
    // owned by the stimulus
    int feed_target = 0;
    logic err_inj = 1'b0;

    function automatic logic [7:0] feedb(input int k);
        return 8'(k * 7 + 3);
    endfunction
    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return 8'(a[7:0] * 3) ^ 8'hA5;
    endfunction

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (acc_pend) fed_cnt++;
        in_valid = (fed_cnt < feed_target);
        in_data  = feedb(fed_cnt);
        acc_pend = in_valid && in_ready;
        if (out_valid) begin
            out_log[out_cnt % 512] = out_data;
            out_cnt++;
        end
        if (mem_req) req_cnt++;
        mem_gnt   = mem_req && (lfsr[0] || lfsr[1]);
        mem_err   = mem_gnt && err_inj;
        mem_rdata = pat(mem_addr);
        if (mem_gnt && mem_we && !err_inj) mem[mem_addr[7:0]] = mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        reg_addr = a;
        #1 rdv = reg_rdata;
    endtask

    task automatic wait_stat(input logic [3:0] mask, input string tag);
        bit hit = 0;
        for (int i = 0; i < 2000; i++) begin
            rd(RA_STAT);
            if ((rdv[3:0] & mask) != 0) begin hit = 1; break; end
        end
        if (!hit) chk(tag, rdv, {28'd0, mask});
    endtask

    function automatic logic [31:0] cmdw(input logic [1:0] o, input logic d, input logic e);
        return {26'd0, e, d, 2'b00, o};
    endfunction

    task automatic run_xfer(input int n, input logic d, input logic e, input logic [31:0] a);
        int fbase, obase, rbase;
        wr(RA_SADDR, a);
        wr(RA_SCNT, n);
        wr(RA_CMD, cmdw(OP_IDLE, d, e));
        fbase = feed_target; obase = out_cnt; rbase = req_cnt;
        wr(RA_CMD, cmdw(OP_START, d, e));
        if (d) feed_target += n;
        wait_stat(4'b0001, "R2 done timeout");
        repeat (3) @(negedge clk);
        rd(RA_STAT);  chk("R2 status done only", rdv, 32'h1);
        rd(RA_REM);   chk("R2 remaining zero", rdv, 32'h0);
        rd(RA_CADDR); chk("R2 current address", rdv, a + 32'(n));
        #1 chk("R12 irq after done", {31'd0, irq}, {31'd0, e});
        if (n == 0) chk("R5 no request on zero count", req_cnt - rbase, 0);
        if (d) begin
            for (int i = 0; i < n; i++)
                chk("R3 memory byte", mem[8'(a + 32'(i))], feedb(fbase + i));
        end else begin
            chk("R4 outbound byte count", out_cnt - obase, n);
            for (int i = 0; i < n; i++)
                chk("R4 outbound byte", out_log[(obase + i) % 512], pat(a + 32'(i)));
        end
        wr(RA_CMD, cmdw(OP_IDLE, d, e));
        rd(RA_STAT); chk("R11 idle clears status", rdv, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        rd(RA_CMD);  chk("R1 command idle", rdv, 32'h0);
        rd(RA_STAT); chk("R1 status zero", rdv, 32'h0);
        #1 chk("R1 no request", {31'd0, mem_req}, 32'h0);
        chk("R1 irq low", {31'd0, irq}, 32'h0);

        wr(RA_SCNT, 5000); rd(RA_SCNT); chk("R6 cap above", rdv, 32'd4096);
        wr(RA_SCNT, 4097); rd(RA_SCNT); chk("R6 cap just above", rdv, 32'd4096);
        wr(RA_SCNT, 4096); rd(RA_SCNT); chk("R6 cap exact", rdv, 32'd4096);

        for (int n = 0; n <= 20; n++)
            for (int d = 0; d < 2; d++)
                run_xfer(n, d[0], n[0], 32'h4000_0000 + 32'(n * 19 + d * 128));

        // R8 abort with a held partial batch
        wr(RA_SADDR, 32'h0000_0040); wr(RA_SCNT, 10);
        wr(RA_CMD, cmdw(OP_IDLE, 1, 1));
        snap = req_cnt;
        wr(RA_CMD, cmdw(OP_START, 1, 1));
        feed_target += 3;
        repeat (20) @(negedge clk);
        rd(RA_CMD); chk("R7 command readback busy", rdv, 32'h31);
        rd(RA_REM); chk("R3 partial batch held", rdv, 32'd10);
        chk("R3 no write for partial batch", req_cnt - snap, 0);
        wr(RA_CMD, cmdw(OP_ABORT, 1, 1));
        repeat (10) @(negedge clk);
        rd(RA_CMD);  chk("R7 abort reads back", rdv, 32'h33);
        rd(RA_STAT); chk("R8 aborted flag", rdv, 32'h4);
        #1 chk("R12 irq on abort", {31'd0, irq}, 32'h1);
        chk("R8 abort discards bytes", req_cnt - snap, 0);
        wr(RA_CMD, cmdw(OP_IDLE, 1, 0));
        rd(RA_CMD);  chk("R8 idle after abort", rdv, 32'h10);
        rd(RA_STAT); chk("R11 idle clears aborted", rdv, 32'h0);

        // R9 flush of a partial batch
        wr(RA_SADDR, 32'h0000_0080); wr(RA_SCNT, 10);
        wr(RA_CMD, cmdw(OP_IDLE, 1, 0));
        snap = feed_target;
        wr(RA_CMD, cmdw(OP_START, 1, 0));
        feed_target += 3;
        repeat (20) @(negedge clk);
        rd(RA_REM); chk("R9 nothing written before flush", rdv, 32'd10);
        wr(RA_CMD, cmdw(OP_FLUSH, 1, 0));
        wait_stat(4'b1000, "R9 flush timeout");
        rd(RA_STAT);  chk("R9 flush-complete flag only", rdv, 32'h8);
        rd(RA_REM);   chk("R9 remaining after flush", rdv, 32'd7);
        rd(RA_CADDR); chk("R9 address after flush", rdv, 32'h83);
        for (int i = 0; i < 3; i++) chk("R9 flushed byte", mem[8'(8'h80 + i)], feedb(snap + i));
        wr(RA_CMD, cmdw(OP_IDLE, 1, 0));

        // R10 error response
        err_inj = 1'b1;
        wr(RA_SADDR, 32'h0000_00C0); wr(RA_SCNT, 5);
        wr(RA_CMD, cmdw(OP_IDLE, 0, 1));
        wr(RA_CMD, cmdw(OP_START, 0, 1));
        wait_stat(4'b0010, "R10 error timeout");
        rd(RA_STAT); chk("R10 error flag", rdv, 32'h2);
        #1 chk("R12 irq on error", {31'd0, irq}, 32'h1);
        rd(RA_REM);  chk("R10 count kept", rdv, 32'd5);
        rd(RA_CADDR); chk("R10 address kept", rdv, 32'hC0);
        snap = req_cnt;
        repeat (20) @(negedge clk);
        chk("R10 requests blocked", req_cnt - snap, 0);
        err_inj = 1'b0;
        wr(RA_CMD, cmdw(OP_IDLE, 0, 0));
        rd(RA_STAT); chk("R11 idle clears error", rdv, 32'h0);
        #1 chk("R12 irq cleared", {31'd0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule